// File: doc/BRIEF.md
# Modem Status Scanner

This block is the modem-control side of a sixteen-line serial multiplexer. For each line it holds four control outputs (line enable, data terminal ready, request to send, secondary transmit). It watches four status inputs per line: ring, carrier, clear to send and secondary receive. A scanner visits one line per clock. Each time it finds a line whose ring or carrier input differs from the copy it last recorded, it records the new value, stops, raises a done flag and leaves that line's number in the control register. If interrupts are enabled, the interrupt output rises in the same cycle.

Software reaches the block through a two-word register port: a control/status word and a per-line status word. Before it touches a line, software stops the scanner and polls until busy reads zero. It then writes the line number into the control word, and reads or writes that line's word. Writing scan enable again restarts the scan and clears done. The register port is plain: every write takes effect at the clock edge it is presented on. A read is a combinational view of the addressed word. There is no stall and no back-pressure.

Top module: `modem_scan_ctl`

## Requirements
- R1: After reset every control output is 0, irq is 0, and with all status inputs at 0 both register words read 0.
- R2: The control word (address 0) reads: bits 3:0 line number, bit 4 busy, bit 5 scan enable, bit 6 interrupt enable, bit 7 done, bit 9 loopback mode. Bits 15, 14, 13 and 12 give the effective ring, carrier, CTS and secondary-receive values of the line in bits 3:0. Bits 8, 10 and 11 read 0.
- R3: While scan enable is 0, a write to the line word (address 1) loads bit 0 line enable, bit 1 DTR, bit 2 RTS and bit 3 secondary transmit of the selected line. Written bits 15:4 have no effect. A read returns {ring, carrier, CTS, secondary receive, secondary transmit, RTS, DTR, line enable} in bits 7:0, with zeros above.
- R4: A line-word write while scan enable is 1 changes no control output.
- R5: While scan enable is 1, done is 0 and no control write occurs, the line number advances by one per clock and wraps from 15 to 0. The scan stops with done set on the first visited line whose ring or carrier differs from its recorded copy, and refreshes that copy, so a change is reported once. The line number holds while done is set.
- R6: A control write on the same edge as a scan step wins. The line number takes the written value and no comparison happens on that edge, so the scan resumes from the written line.
- R7: A control write with bit 5 set clears done. Any other ordinary control write sets done if bit 7 is written 1 and otherwise leaves it unchanged.
- R8: irq equals done AND interrupt enable in every cycle, with no added delay.
- R9: A control write that clears scan enable while scan enable is 1 and done is 0 makes busy read 1 for exactly the next cycle. Busy is 0 at every other time.
- R10: Writing bit 11 of the control word clears scan enable, done, busy and the line number. It re-records every line's current ring and carrier, so changes that happened earlier are dropped. The other bits of that write are ignored, and interrupt enable and loopback keep their values.
- R11: Writing bit 10 of the control word does everything bit 11 does. It also clears every control output, interrupt enable and loopback mode.
- R12: In loopback mode each line's effective carrier is its DTR, ring is its secondary transmit, CTS is its RTS and secondary receive is its line enable. These values feed both the register reads and the scanner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control word, 1 the line word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed word |
| irq | output | 1 | Interrupt request |
| ring_in | input | 16 | Per-line ring input |
| car_in | input | 16 | Per-line carrier input |
| cts_in | input | 16 | Per-line clear-to-send input |
| srx_in | input | 16 | Per-line secondary receive input |
| le_out | output | 16 | Per-line line enable |
| dtr_out | output | 16 | Per-line data terminal ready |
| rts_out | output | 16 | Per-line request to send |
| stx_out | output | 16 | Per-line secondary transmit |

## Verification
The scanner step and a control write can fall on the same clock edge. The bench provokes this by flipping carrier on line 12 while, on that same edge, writing scan enable with line number 12. It expects the line field to read 12 with done clear one cycle later, then done set on line 12 one cycle after that. This shows the write won and the comparison waited one edge. A second collision is between a line-word write and an active scan: the bench presents that write while the scanner is running and checks that the control outputs do not move.

// File: rtl/mscan_pkg.sv
package mscan_pkg;
  // control word bit positions (software decodes these)
  localparam int unsigned CSR_BUSY    = 4;
  localparam int unsigned CSR_SCAN    = 5;
  localparam int unsigned CSR_IE      = 6;
  localparam int unsigned CSR_DONE    = 7;
  localparam int unsigned CSR_LOOP    = 9;
  localparam int unsigned CSR_CLRALL  = 10;
  localparam int unsigned CSR_CLRSCAN = 11;
  localparam int unsigned CSR_LINE_W  = 4;

  // per-line control bits, bit 0 = line enable
  typedef struct packed {
    logic stx;
    logic rts;
    logic dtr;
    logic le;
  } lctl_t;
endpackage

// File: rtl/mscan_lines.sv
module mscan_lines
  import mscan_pkg::*;
#(
  parameter int unsigned N_LINES = 16,
  localparam int unsigned LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [LW-1:0]      wr_idx,
  input  lctl_t              wr_val,
  input  logic               clr_all,
  input  logic               loop_mode,
  input  logic [N_LINES-1:0] ring_in,
  input  logic [N_LINES-1:0] car_in,
  input  logic [N_LINES-1:0] cts_in,
  input  logic [N_LINES-1:0] srx_in,
  output logic [N_LINES-1:0] le_o,
  output logic [N_LINES-1:0] dtr_o,
  output logic [N_LINES-1:0] rts_o,
  output logic [N_LINES-1:0] stx_o,
  output logic [N_LINES-1:0] ring_eff,
  output logic [N_LINES-1:0] car_eff,
  output logic [N_LINES-1:0] cts_eff,
  output logic [N_LINES-1:0] srx_eff
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    lctl_t ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ctl_q <= '0;
      else if (clr_all)                         ctl_q <= '0;
      else if (wr_en && wr_idx == LW'(i))       ctl_q <= wr_val;
    end

    assign le_o[i]  = ctl_q.le;
    assign dtr_o[i] = ctl_q.dtr;
    assign rts_o[i] = ctl_q.rts;
    assign stx_o[i] = ctl_q.stx;

    // loopback: control bits feed back as status
    assign car_eff[i]  = loop_mode ? ctl_q.dtr : car_in[i];
    assign ring_eff[i] = loop_mode ? ctl_q.stx : ring_in[i];
    assign cts_eff[i]  = loop_mode ? ctl_q.rts : cts_in[i];
    assign srx_eff[i]  = loop_mode ? ctl_q.le  : srx_in[i];
  end
endmodule

// File: rtl/mscan_engine.sv
module mscan_engine
  import mscan_pkg::*;
#(
  parameter int unsigned N_LINES = 16,
  localparam int unsigned LW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam logic [LW-1:0] LAST = LW'(N_LINES - 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_wr,
  input  logic [15:0]        csr_wdata,
  input  logic [N_LINES-1:0] ring_eff,
  input  logic [N_LINES-1:0] car_eff,
  output logic [LW-1:0]      line_q,
  output logic               scan_en_q,
  output logic               ie_q,
  output logic               loop_q,
  output logic               done_q,
  output logic               busy_q
);
  logic [N_LINES-1:0] car_seen_q, ring_seen_q;
  logic hit, clr_any, clr_all;

  assign hit     = (car_eff[line_q] != car_seen_q[line_q]) ||
                   (ring_eff[line_q] != ring_seen_q[line_q]);
  assign clr_all = csr_wdata[CSR_CLRALL];
  assign clr_any = csr_wdata[CSR_CLRSCAN] | clr_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q      <= '0;
      scan_en_q   <= 1'b0;
      ie_q        <= 1'b0;
      loop_q      <= 1'b0;
      done_q      <= 1'b0;
      busy_q      <= 1'b0;
      car_seen_q  <= '0;
      ring_seen_q <= '0;
    end else if (csr_wr) begin
      if (clr_any) begin
        line_q      <= '0;
        scan_en_q   <= 1'b0;
        done_q      <= 1'b0;
        busy_q      <= 1'b0;
        car_seen_q  <= car_eff;
        ring_seen_q <= ring_eff;
        if (clr_all) begin
          ie_q   <= 1'b0;
          loop_q <= 1'b0;
        end
      end else begin
        line_q    <= csr_wdata[LW-1:0];
        scan_en_q <= csr_wdata[CSR_SCAN];
        ie_q      <= csr_wdata[CSR_IE];
        loop_q    <= csr_wdata[CSR_LOOP];
        done_q    <= csr_wdata[CSR_SCAN] ? 1'b0 : (done_q | csr_wdata[CSR_DONE]);
        busy_q    <= scan_en_q && !done_q && !csr_wdata[CSR_SCAN];
      end
    end else begin
      busy_q <= 1'b0;
      if (scan_en_q && !done_q) begin
        if (hit) begin
          done_q              <= 1'b1;
          car_seen_q[line_q]  <= car_eff[line_q];
          ring_seen_q[line_q] <= ring_eff[line_q];
        end else begin
          line_q <= (line_q == LAST) ? '0 : line_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/modem_scan_ctl.sv
module modem_scan_ctl
  import mscan_pkg::*;
#(
  parameter int unsigned N_LINES = 16,
  localparam int unsigned LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  output logic               irq,
  input  logic [N_LINES-1:0] ring_in,
  input  logic [N_LINES-1:0] car_in,
  input  logic [N_LINES-1:0] cts_in,
  input  logic [N_LINES-1:0] srx_in,
  output logic [N_LINES-1:0] le_out,
  output logic [N_LINES-1:0] dtr_out,
  output logic [N_LINES-1:0] rts_out,
  output logic [N_LINES-1:0] stx_out
);
  logic [N_LINES-1:0] ring_eff, car_eff, cts_eff, srx_eff;
  logic [LW-1:0] eng_line;
  logic eng_se, eng_ie, eng_loop, eng_done, eng_busy;
  logic csr_wr, line_wr;
  logic [CSR_LINE_W-1:0] line4;
  logic [15:0] csr_word, line_word;

  assign csr_wr  = reg_wr && !reg_addr;
  assign line_wr = reg_wr && reg_addr && !eng_se;

  mscan_lines #(.N_LINES(N_LINES)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (line_wr),
    .wr_idx    (eng_line),
    .wr_val    (lctl_t'(reg_wdata[3:0])),
    .clr_all   (csr_wr && reg_wdata[CSR_CLRALL]),
    .loop_mode (eng_loop),
    .ring_in   (ring_in),
    .car_in    (car_in),
    .cts_in    (cts_in),
    .srx_in    (srx_in),
    .le_o      (le_out),
    .dtr_o     (dtr_out),
    .rts_o     (rts_out),
    .stx_o     (stx_out),
    .ring_eff  (ring_eff),
    .car_eff   (car_eff),
    .cts_eff   (cts_eff),
    .srx_eff   (srx_eff)
  );

  mscan_engine #(.N_LINES(N_LINES)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_wdata (reg_wdata),
    .ring_eff  (ring_eff),
    .car_eff   (car_eff),
    .line_q    (eng_line),
    .scan_en_q (eng_se),
    .ie_q      (eng_ie),
    .loop_q    (eng_loop),
    .done_q    (eng_done),
    .busy_q    (eng_busy)
  );

  assign line4 = CSR_LINE_W'(eng_line);

  assign csr_word = {ring_eff[eng_line], car_eff[eng_line],
                     cts_eff[eng_line], srx_eff[eng_line],
                     2'b00, eng_loop, 1'b0,
                     eng_done, eng_ie, eng_se, eng_busy, line4};

  assign line_word = {8'h00, ring_eff[eng_line], car_eff[eng_line],
                      cts_eff[eng_line], srx_eff[eng_line],
                      stx_out[eng_line], rts_out[eng_line],
                      dtr_out[eng_line], le_out[eng_line]};

  assign reg_rdata = reg_addr ? line_word : csr_word;
  assign irq       = eng_done && eng_ie;
endmodule

// File: rtl/mscan_checker.sv
module mscan_checker #(
  parameter int unsigned N_LINES = 16,
  localparam int unsigned LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_addr,
  input logic [15:0]        reg_wdata,
  input logic [15:0]        reg_rdata,
  input logic               irq,
  input logic [N_LINES-1:0] le_out,
  input logic [N_LINES-1:0] dtr_out,
  input logic [N_LINES-1:0] rts_out,
  input logic [N_LINES-1:0] stx_out,
  input logic [LW-1:0]      line_q,
  input logic               scan_en_q,
  input logic               done_q,
  input logic               busy_q
);
  logic [LW-1:0] nxt_line;
  assign nxt_line = (line_q == LW'(N_LINES - 1)) ? '0 : line_q + 1'b1;

  a_r8_irq_matches_word: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> (irq == (reg_rdata[7] && reg_rdata[6])));

  a_r9_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);

  a_r5_done_holds_line: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !reg_wr) |=> (done_q && $stable(line_q)));

  a_r5_step_or_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en_q && !done_q && !reg_wr) |=> (done_q || line_q == $past(nxt_line)));

  a_r4_no_line_write_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && scan_en_q) |=>
      ($stable(le_out) && $stable(dtr_out) && $stable(rts_out) && $stable(stx_out)));

  a_r11_clear_all_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[10]) |=>
      (le_out == '0 && dtr_out == '0 && rts_out == '0 && stx_out == '0 && !scan_en_q));
endmodule

bind modem_scan_ctl mscan_checker #(.N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .le_out    (le_out),
  .dtr_out   (dtr_out),
  .rts_out   (rts_out),
  .stx_out   (stx_out),
  .line_q    (eng_line),
  .scan_en_q (eng_se),
  .done_q    (eng_done),
  .busy_q    (eng_busy)
);

// File: tb/tb_modem_scan_ctl.sv
`timescale 1ns/100ps
module tb_modem_scan_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq;
  logic [15:0] ring_in = '0, car_in = '0, cts_in = '0, srx_in = '0;
  logic [15:0] le_out, dtr_out, rts_out, stx_out;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  modem_scan_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .ring_in(ring_in), .car_in(car_in), .cts_in(cts_in), .srx_in(srx_in),
    .le_out(le_out), .dtr_out(dtr_out), .rts_out(rts_out), .stx_out(stx_out)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_done(output bit got);
    logic [15:0] v;
    got = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rd(1'b0, v);
      if (v[7]) begin got = 1; return; end
    end
  endtask

  function automatic logic [15:0] exp_csr(input int l, input logic [3:0] hi7_4, input bit loopm);
    return {ring_in[l], car_in[l], cts_in[l], srx_in[l], 2'b00, loopm, 1'b0, hi7_4, 4'(l)};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, e, s_le, s_dtr, s_rts, s_stx;
    logic [3:0] ctl_exp [16];
    bit got;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk(v == 16'h0, "R1 csr", v, 16'h0);
    rd(1'b1, v); chk(v == 16'h0, "R1 line word", v, 16'h0);
    chk({le_out | dtr_out | rts_out | stx_out} == 16'h0, "R1 outputs",
        le_out | dtr_out | rts_out | stx_out, 16'h0);
    chk(irq == 1'b0, "R1 irq", {15'h0, irq}, 16'h0);

    // R3 write every line, upper bits set to show they are ignored
    cts_in = 16'h3C5A; srx_in = 16'h0FF0;
    for (int l = 0; l < 16; l++) begin
      ctl_exp[l] = 4'((l * 7 + 3) % 16);
      wr(1'b0, 16'(l));
      wr(1'b1, 16'hFFF0 | 16'(ctl_exp[l]));
    end
    for (int l = 0; l < 16; l++) begin
      e = {12'h0, ctl_exp[l]};
      chk(le_out[l] == e[0] && dtr_out[l] == e[1] && rts_out[l] == e[2] && stx_out[l] == e[3],
          "R3 outputs", {12'h0, stx_out[l], rts_out[l], dtr_out[l], le_out[l]}, e);
    end
    ring_in = 16'h1248; car_in = 16'h8001;
    for (int l = 0; l < 16; l++) begin
      wr(1'b0, 16'(l));
      rd(1'b1, v);
      e = {8'h00, ring_in[l], car_in[l], cts_in[l], srx_in[l], ctl_exp[l]};
      chk(v == e, "R3 line readback", v, e);
    end

    // R2 control word layout
    foreach (ctl_exp[l]) if (l == 0 || l == 3 || l == 15) begin
      wr(1'b0, 16'h0040 | 16'(l));
      rd(1'b0, v); e = exp_csr(l, 4'b0100, 1'b0);
      chk(v == e, "R2 csr layout", v, e);
    end

    // R7 / R8 done writes and irq
    wr(1'b0, 16'h0800);
    wr(1'b0, 16'h00C0);
    rd(1'b0, v); chk(v[7] && irq, "R8 irq with done+ie", {15'h0, irq}, 16'h1);
    wr(1'b0, 16'h0080);
    chk(!irq, "R8 irq gated by ie", {15'h0, irq}, 16'h0);
    wr(1'b0, 16'h0040);
    rd(1'b0, v); chk(v[7] == 1'b1, "R7 done kept", v, v | 16'h0080);
    wr(1'b0, 16'h0060);
    rd(1'b0, v); chk(v[7] == 1'b0 && !irq, "R7 resume clears done", v, v & 16'hFF7F);

    // R9 busy after stopping an active scan
    wr(1'b0, 16'h0000);
    rd(1'b0, v); chk(v[4] == 1'b1, "R9 busy set", v, v | 16'h0010);
    @(negedge clk);
    rd(1'b0, v); chk(v[4] == 1'b0, "R9 busy cleared", v, v & 16'hFFEF);
    wr(1'b0, 16'h0000);
    rd(1'b0, v); chk(v[4] == 1'b0, "R9 no busy when idle", v, v & 16'hFFEF);

    // R4 line writes ignored while scanning
    wr(1'b0, 16'h0800);
    wr(1'b0, 16'h0020);
    s_le = le_out; s_dtr = dtr_out; s_rts = rts_out; s_stx = stx_out;
    wr(1'b1, 16'h000F);
    wr(1'b1, 16'h0000);
    chk(le_out == s_le, "R4 le", le_out, s_le);
    chk(dtr_out == s_dtr, "R4 dtr", dtr_out, s_dtr);
    chk(rts_out == s_rts, "R4 rts", rts_out, s_rts);
    chk(stx_out == s_stx, "R4 stx", stx_out, s_stx);
    wr(1'b0, 16'h0000);

    // R5 sweep: every line, carrier then ring
    wr(1'b0, 16'h0800);
    wr(1'b0, 16'h0060);
    for (int k = 0; k < 16; k++) begin
      for (int kind = 0; kind < 2; kind++) begin
        @(negedge clk);
        if (kind == 0) car_in[k] = ~car_in[k]; else ring_in[k] = ~ring_in[k];
        wait_done(got);
        chk(got, "R5 change detected", {15'h0, got}, 16'h1);
        rd(1'b0, v);
        chk(v[3:0] == 4'(k), "R5 reported line", {12'h0, v[3:0]}, 16'(k));
        chk(irq, "R8 irq on detection", {15'h0, irq}, 16'h1);
        e = (kind == 0) ? {15'h0, car_in[k]} : {15'h0, ring_in[k]};
        chk(((kind == 0) ? v[14] : v[15]) == e[0], "R2 flag of stopped line", v, e);
        wr(1'b0, 16'h0060);
        repeat (20) @(negedge clk);
        rd(1'b0, v);
        chk(v[7] == 1'b0, "R5 reported once", v, v & 16'hFF7F);
      end
    end

    // R5 scan order: lowest line after start position reported first
    wr(1'b0, 16'h0800);
    car_in[3] = ~car_in[3]; ring_in[9] = ~ring_in[9];
    wr(1'b0, 16'h0020);
    wait_done(got);
    rd(1'b0, v); chk(got && v[3:0] == 4'd3, "R5 first of two", v, 16'h3);
    wr(1'b0, 16'h0023);
    wait_done(got);
    rd(1'b0, v); chk(got && v[3:0] == 4'd9, "R5 second of two", v, 16'h9);
    wr(1'b0, 16'h0800);

    // R6 control write on the same edge as a scan step
    wr(1'b0, 16'h0020);
    repeat (5) @(negedge clk);
    car_in[12] = ~car_in[12];
    reg_addr = 1'b0; reg_wdata = 16'h002C; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(1'b0, v); chk(v[7] == 1'b0 && v[3:0] == 4'd12, "R6 write wins edge", v, 16'h002C | (v & 16'hF000));
    @(negedge clk);
    rd(1'b0, v); chk(v[7] == 1'b1 && v[3:0] == 4'd12, "R6 compare next edge", v, 16'h00AC | (v & 16'hF000));
    wr(1'b0, 16'h0800);

    // R10 clear scan drops pending changes
    car_in[7] = ~car_in[7];
    wr(1'b0, 16'h0805);
    rd(1'b0, v); chk((v & 16'h00BF) == 16'h0, "R10 fields cleared", v & 16'h00BF, 16'h0);
    wr(1'b0, 16'h0020);
    repeat (40) @(negedge clk);
    rd(1'b0, v); chk(v[7] == 1'b0, "R10 stale change dropped", v, v & 16'hFF7F);
    wr(1'b0, 16'h0000);

    // R11 clear all
    wr(1'b0, 16'h0042);
    wr(1'b1, 16'h000F);
    chk(dtr_out[2] == 1'b1, "R11 precondition", {15'h0, dtr_out[2]}, 16'h1);
    wr(1'b0, 16'h0400);
    chk((le_out | dtr_out | rts_out | stx_out) == 16'h0, "R11 outputs cleared",
        le_out | dtr_out | rts_out | stx_out, 16'h0);
    rd(1'b0, v); chk((v & 16'h0FFF) == 16'h0, "R11 csr cleared", v & 16'h0FFF, 16'h0);

    // R12 loopback
    ring_in[5] = 1'b1; car_in[5] = 1'b0; cts_in[5] = 1'b1; srx_in[5] = 1'b1;
    wr(1'b0, 16'h0205);
    wr(1'b1, 16'h0002);
    rd(1'b1, v); chk(v == 16'h0042, "R12 loop dtr->car", v, 16'h0042);
    wr(1'b1, 16'h000D);
    rd(1'b1, v); chk(v == 16'h00BD, "R12 loop le/rts/stx", v, 16'h00BD);
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'h0800);
    wr(1'b0, 16'h0205);
    wr(1'b1, 16'h0002);
    wr(1'b0, 16'h0220);
    wait_done(got);
    rd(1'b0, v);
    chk(got && v[3:0] == 4'd5 && v[14] == 1'b1, "R12 loop change scanned", v, 16'h42A5);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule